// File: doc/BRIEF.md
# Dual-Tap Power-of-Two Reference Divider

This block takes one reference clock and derives from it two comparison-rate enables, one for each of two synthesiser loops. A single free-running binary counter acts as the divider chain. Each loop picks its own tap on that chain with a 3-bit ratio code, so both comparison rates are power-of-two fractions of the same reference and stay phase-related. Loop 1 divides by 2 to 256. Loop 2 covers the octave above, dividing by 4 to 512.

Each output is a single-cycle strobe. A companion signal per loop toggles on every strobe. It runs at half the comparison rate and is meant for a test observation port. Software may rewrite either ratio code at any moment. The block holds a new code until the chain reaches its longest terminal count and only then applies it. No strobe period is ever cut short, and no runt pulse appears.

Top module: `refdiv_dual`

## Requirements
- R1: While `rst` is high at a clock edge, the chain clears to zero, both strobes go low and both half-rate toggles go low. Each loop's ratio code is loaded from its input.
- R2: With active loop-1 code c (0..7), `cmp1` is high for exactly one reference cycle in every 2^(c+1) cycles. Counting the first rising edge after reset release as edge 1, `cmp1` is high after edge e exactly when e is a multiple of 2^(c+1).
- R3: With active loop-2 code c (0..7), `cmp2` is high after edge e exactly when e is a multiple of 2^(c+2). Code 0 gives a ratio of 4 and code 7 a ratio of 512.
- R4: The two ratio codes are independent. Any of the 64 code pairs produces both loop patterns at once, with no influence of one code on the other loop's output.
- R5: A code presented at the input becomes active only at edges e that are multiples of 512. The strobe at such an edge still follows the old code, and the new code governs from edge e+1 on. A code change between those points has no effect on the outputs.
- R6: `half1` and `half2` start at 0 after reset. Each inverts at the same edge that raises its loop's strobe, and is otherwise unchanged.
- R7: A strobe is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| code1 | input | 3 | Loop-1 ratio code, ratio 2^(code1+1) |
| code2 | input | 3 | Loop-2 ratio code, ratio 2^(code2+2) |
| cmp1 | output | 1 | Loop-1 comparison strobe, one cycle wide |
| cmp2 | output | 1 | Loop-2 comparison strobe, one cycle wide |
| half1 | output | 1 | Loop-1 toggle at half the comparison rate |
| half2 | output | 1 | Loop-2 toggle at half the comparison rate |

## Verification
The bench sweeps all 64 pairs of ratio codes. Each pair runs for two full chain periods, which separates a wrong tap offset between the loops and cross-coupling of the codes. Inside each window the codes are rewritten at a staggered offset that never lands on the chain's terminal count. A design that applies a code immediately, rather than at the 512-cycle boundary, therefore produces early or shortened strobes. A second reset in the middle of a run, with nonzero codes, checks that the chain, the toggles and the loaded codes all restart from a known phase.

// File: rtl/refdiv_pkg.sv
package refdiv_pkg;
  localparam int CODE_W    = 3;
  localparam int NUM_LOOPS = 2;
  // log2 of the smallest ratio for each loop (loop index 0 = loop 1)
  localparam int LOOP_BASE [NUM_LOOPS] = '{1, 2};

  function automatic int max_base();
    int m;
    m = 0;
    for (int i = 0; i < NUM_LOOPS; i++)
      if (LOOP_BASE[i] > m) m = LOOP_BASE[i];
    return m;
  endfunction

  // chain must reach the largest tap of the highest loop
  localparam int CHAIN_W = max_base() + (1 << CODE_W) - 1;
endpackage

// File: rtl/refdiv_chain.sv
module refdiv_chain #(
  parameter int CHAIN_W = 9
) (
  input  logic               clk,
  input  logic               rst,
  output logic [CHAIN_W-1:0] cnt,
  output logic               wrap
);
  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else     cnt <= cnt + 1'b1;
  end

  // terminal count of the longest ratio: every tap finishes its period here
  assign wrap = &cnt;

  AST_CHAIN_STEP: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> cnt == CHAIN_W'($past(cnt) + 1'b1)); // R1
endmodule

// File: rtl/refdiv_tap.sv
module refdiv_tap #(
  parameter int CHAIN_W = 9,
  parameter int CODE_W  = 3,
  parameter int BASE    = 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [CHAIN_W-1:0] cnt,
  input  logic               wrap,
  input  logic [CODE_W-1:0]  code,
  output logic               strb,
  output logic               tog
);
  logic [CODE_W-1:0]  act;
  logic [CHAIN_W-1:0] mask;
  logic               hit;

  // code is latched only at the chain's terminal count
  always_ff @(posedge clk) begin
    if (rst)       act <= code;
    else if (wrap) act <= code;
  end

  always_comb begin
    mask = '0;
    for (int i = 0; i < CHAIN_W; i++)
      if (i < BASE + int'(act)) mask[i] = 1'b1;
  end

  assign hit = (cnt & mask) == mask;

  always_ff @(posedge clk) begin
    if (rst) begin
      strb <= 1'b0;
      tog  <= 1'b0;
    end else begin
      strb <= hit;
      tog  <= tog ^ hit;
    end
  end

  AST_CODE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(wrap)) |-> $stable(act)); // R5

  AST_STRB_SINGLE: assert property (@(posedge clk) disable iff (rst)
    strb |=> !strb); // R7

  AST_TOG_TRACKS: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ((tog != $past(tog)) == strb)); // R6
endmodule

// File: rtl/refdiv_dual.sv
module refdiv_dual
  import refdiv_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [CODE_W-1:0] code1,
  input  logic [CODE_W-1:0] code2,
  output logic              cmp1,
  output logic              cmp2,
  output logic              half1,
  output logic              half2
);
  logic [CHAIN_W-1:0]   cnt;
  logic                 wrap;
  logic [CODE_W-1:0]    codes [NUM_LOOPS];
  logic [NUM_LOOPS-1:0] strb;
  logic [NUM_LOOPS-1:0] tog;

  assign codes[0] = code1;
  assign codes[1] = code2;

  refdiv_chain #(.CHAIN_W(CHAIN_W)) u_chain (
    .clk  (clk),
    .rst  (rst),
    .cnt  (cnt),
    .wrap (wrap)
  );

  for (genvar g = 0; g < NUM_LOOPS; g++) begin : g_loop
    refdiv_tap #(
      .CHAIN_W (CHAIN_W),
      .CODE_W  (CODE_W),
      .BASE    (LOOP_BASE[g])
    ) u_tap (
      .clk  (clk),
      .rst  (rst),
      .cnt  (cnt),
      .wrap (wrap),
      .code (codes[g]),
      .strb (strb[g]),
      .tog  (tog[g])
    );
  end

  assign cmp1  = strb[0];
  assign cmp2  = strb[1];
  assign half1 = tog[0];
  assign half2 = tog[1];

  AST_RESET_QUIET: assert property (@(posedge clk)
    $past(rst) |-> (!cmp1 && !cmp2 && !half1 && !half2)); // R1
endmodule

// File: tb/refdiv_dual_bench.sv
module refdiv_dual_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [2:0] code1 = 3'd0, code2 = 3'd0;
  logic cmp1, cmp2, half1, half2;

  int compared = 0, mismatched = 0;
  int e;                       // edges since reset release
  int a1, a2;                  // model active codes
  bit eh1, eh2;                // model toggles
  bit finished = 0;

  always #5 clk = ~clk;

  refdiv_dual u_refdiv_dual (
    .clk(clk), .rst(rst), .code1(code1), .code2(code2),
    .cmp1(cmp1), .cmp2(cmp2), .half1(half1), .half2(half2)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s edge=%0d actual=%b expected=%b", req, e, act, exp);
    end
  endtask

  // one reference edge, model update, compare at the falling edge
  task automatic step();
    bit s1, s2;
    @(posedge clk);
    e++;
    s1 = (e % (1 << (a1 + 1))) == 0;
    s2 = (e % (1 << (a2 + 2))) == 0;
    if (s1) eh1 = !eh1;
    if (s2) eh2 = !eh2;
    if (e % 512 == 0) begin a1 = code1; a2 = code2; end
    @(negedge clk);
    chk("R2,R5", cmp1, s1);
    chk("R3,R5", cmp2, s2);
    chk("R6", half1, eh1);
    chk("R6", half2, eh2);
  endtask

  task automatic do_reset(input logic [2:0] c1, input logic [2:0] c2);
    @(negedge clk);
    rst = 1'b1; code1 = c1; code2 = c2;
    repeat (2) @(negedge clk);
    chk("R1", cmp1, 1'b0);
    chk("R1", cmp2, 1'b0);
    chk("R1", half1, 1'b0);
    chk("R1", half2, 1'b0);
    rst = 1'b0;
    e = 0; a1 = c1; a2 = c2; eh1 = 0; eh2 = 0;
  endtask

  initial begin
    do_reset(3'd0, 3'd0);
    // R4: every pair of codes, rewritten mid-window (R5)
    for (int p = 0; p < 64; p++) begin
      for (int n = 0; n < 1024; n++) begin
        if (n == 100 + (p * 37) % 300) begin
          code1 = 3'(p % 8);
          code2 = 3'(p / 8);
        end
        if (n == 700) begin
          code1 = 3'(7 - p % 8);
          code2 = 3'(p % 8);
        end
        step();
      end
    end
    // reset mid-run with nonzero codes (R1)
    do_reset(3'd5, 3'd3);
    for (int n = 0; n < 1100; n++) step();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule